// File: doc/BRIEF.md
# Data eye centering calculator

This block takes the measured timing window of every bit in a data group and works out where the strobe and each bit's delay must sit so that all bit windows line up on a common centre. The window of each bit is given as a signed left edge and a signed right edge. The block also receives the delay each bit currently has and the strobe delay the search started from. It returns a new strobe delay, a new delay for every bit, the worst data-side and strobe-side margins, and a pass flag. Finding the edges and programming the PHY are left to the surrounding calibration logic.

A single pulse on `start_i` loads all inputs from flat buses. A small state machine then makes two passes over the bits, one bit per clock. The first pass finds the narrowest offset. A single cycle then settles the strobe. The second pass computes each bit's shift and accumulates the margins. `done_o` rises for one cycle together with the pass flag, and every result holds until the next run. The parameter `MOVE_STROBE` selects the variant. When it is 1 (read side) the strobe may be moved within its range. When it is 0 (write side) the strobe stays where it was and only the bit delays move.

Top module: `eye_centre_calc`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o` and `pass_o` are 0, and `strobe_dly_o`, `dly_o` and both margins are 0.
- R2: For each bit the offset is left minus right. The block keeps the smallest offset over all bits.
- R3: A positive minimum is incremented before it is halved. The halving is a signed division that truncates toward zero, so a minimum of -5 halves to -2 and a minimum of 5 halves to 3.
- R4: With `MOVE_STROBE`=1 the new strobe delay is the start value minus the halved minimum, clamped to 0..`STROBE_MAX`. The effective move is the start value minus the new strobe delay.
- R5: With `MOVE_STROBE`=0 the strobe delay output equals the start value and the effective move is 0, while the halved minimum is still used for the shifts.
- R6: The shift of bit i is (offset_i minus minimum offset)/2 plus (halved minimum minus effective move). The new delay is the current delay plus the shift. Bit i uses bits [i*DLY_W +: DLY_W] of `cur_dly_i` and `dly_o`, and bits [i*EDGE_W +: EDGE_W] of the edge buses, as two's complement.
- R7: If the current delay plus the shift exceeds `DLY_MAX`, the new delay is `DLY_MAX`. If it is below 0, the new delay is 0.
- R8: `dq_margin_o` is the minimum over bits of left minus clamped shift minus move. `strobe_margin_o` is the minimum of right plus clamped shift plus move. Both start from `DLY_MAX`+1.
- R9: `pass_o` is 1 exactly when both margins are zero or greater.
- R10: `done_o` is a one-cycle pulse per run. A `start_i` that arrives while `busy_o` is 1 is ignored. Results hold while the block is idle, even if the inputs change.
- R11: `done_o` is high in the cycle that follows the 2*NBITS+1-th rising edge after the edge that accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Loads the inputs and starts a run when idle |
| left_edges_i | input | NBITS*EDGE_W | Signed left edge per bit |
| right_edges_i | input | NBITS*EDGE_W | Signed right edge per bit |
| cur_dly_i | input | NBITS*DLY_W | Current delay per bit |
| strobe_start_i | input | DQS_W | Starting strobe delay |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Both margins non-negative |
| strobe_dly_o | output | DQS_W | New strobe delay |
| dly_o | output | NBITS*DLY_W | New delay per bit |
| dq_margin_o | output | MARGIN_W | Signed worst data-side margin |
| strobe_margin_o | output | MARGIN_W | Signed worst strobe-side margin |

## Verification
Some properties are checked on every clock by the assertions. The kept minimum never exceeds an offset that has been scanned. The strobe result stays inside its range, and on the write side it equals the latched start value. Every new bit delay lies within 0..`DLY_MAX`. `done_o` is a single pulse that arrives a fixed number of cycles after `start`. A start that arrives mid-run leaves the latched inputs untouched. The arithmetic itself can only be shown by the bench's scenarios, which compare results against a separate model: the rounding of positive and negative minima, clamping at both ends of the strobe and delay ranges, the feedback of the clamp loss into the shifts, and a failing margin.

// File: rtl/eye_centre_pkg.sv
package eye_centre_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_STROBE,
    ST_SHIFT
  } ctr_state_e;
endpackage

// File: rtl/eye_min_scan.sv
module eye_min_scan #(
  parameter int MW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic                 en_i,
  input  logic signed [MW-1:0] val_i,
  output logic signed [MW-1:0] min_o
);
  logic have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      min_o  <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
    end else if (en_i) begin
      have_q <= 1'b1;
      // strict compare: an equal later offset does not replace the kept one
      if (!have_q || (val_i < min_o)) min_o <= val_i;
    end
  end

  p_min_le_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clear_i) |=> (min_o <= $past(val_i)));
endmodule

// File: rtl/eye_strobe_calc.sv
module eye_strobe_calc #(
  parameter int MW          = 16,
  parameter int DQS_W       = 5,
  parameter int STROBE_MAX  = 28,
  parameter bit MOVE_STROBE = 1'b1
) (
  input  logic signed [MW-1:0] min_mid_i,
  input  logic [DQS_W-1:0]     start_i,
  output logic signed [MW-1:0] half_o,
  output logic signed [MW-1:0] move_o,
  output logic [DQS_W-1:0]     strobe_o
);
  localparam logic signed [MW-1:0] ONE  = MW'(1);
  localparam logic signed [MW-1:0] TWO  = MW'(2);
  localparam logic signed [MW-1:0] SMAX = MW'(STROBE_MAX);

  logic signed [MW-1:0] start_s;
  logic signed [MW-1:0] biased;

  always_comb begin
    start_s = '0;
    start_s[DQS_W-1:0] = start_i;
    biased = (min_mid_i > 0) ? (min_mid_i + ONE) : min_mid_i;
    half_o = biased / TWO;
  end

  generate
    if (MOVE_STROBE) begin : g_read
      logic signed [MW-1:0] cand;
      logic signed [MW-1:0] clamped;
      always_comb begin
        cand = start_s - half_o;
        if (cand < 0)         clamped = '0;
        else if (cand > SMAX) clamped = SMAX;
        else                  clamped = cand;
        move_o   = start_s - clamped;
        strobe_o = clamped[DQS_W-1:0];
      end
    end else begin : g_write
      always_comb begin
        move_o   = '0;
        strobe_o = start_i;
      end
    end
  endgenerate
endmodule

// File: rtl/eye_bit_shift.sv
module eye_bit_shift #(
  parameter int MW      = 16,
  parameter int DLY_W   = 5,
  parameter int DLY_MAX = 28
) (
  input  logic signed [MW-1:0] mid_i,
  input  logic signed [MW-1:0] min_mid_i,
  input  logic signed [MW-1:0] half_i,
  input  logic signed [MW-1:0] move_i,
  input  logic signed [MW-1:0] left_i,
  input  logic signed [MW-1:0] right_i,
  input  logic [DLY_W-1:0]     cur_i,
  output logic [DLY_W-1:0]     new_o,
  output logic signed [MW-1:0] lmarg_o,
  output logic signed [MW-1:0] rmarg_o
);
  localparam logic signed [MW-1:0] DMAX_S = MW'(DLY_MAX);

  logic signed [MW-1:0] cur_s;
  logic signed [MW-1:0] shift_pre;
  logic signed [MW-1:0] shift;
  logic signed [MW-1:0] sum;

  always_comb begin
    cur_s = '0;
    cur_s[DLY_W-1:0] = cur_i;
    // full-resolution difference is halved here only, keeping round-off small
    shift_pre = ((mid_i - min_mid_i) >>> 1) + (half_i - move_i);
    sum = cur_s + shift_pre;
    if (sum > DMAX_S)  shift = DMAX_S - cur_s;
    else if (sum < 0)  shift = -cur_s;
    else               shift = shift_pre;
    sum     = cur_s + shift;
    new_o   = sum[DLY_W-1:0];
    lmarg_o = left_i - shift - move_i;
    rmarg_o = right_i + shift + move_i;
  end
endmodule

// File: rtl/eye_centre_calc.sv
module eye_centre_calc
  import eye_centre_pkg::*;
#(
  parameter int NBITS       = 8,
  parameter int EDGE_W      = 8,
  parameter int DLY_W       = 5,
  parameter int DLY_MAX     = 28,
  parameter int DQS_W       = 5,
  parameter int STROBE_MAX  = 28,
  parameter int MARGIN_W    = 16,
  parameter bit MOVE_STROBE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [NBITS*EDGE_W-1:0]   left_edges_i,
  input  logic [NBITS*EDGE_W-1:0]   right_edges_i,
  input  logic [NBITS*DLY_W-1:0]    cur_dly_i,
  input  logic [DQS_W-1:0]          strobe_start_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      pass_o,
  output logic [DQS_W-1:0]          strobe_dly_o,
  output logic [NBITS*DLY_W-1:0]    dly_o,
  output logic signed [MARGIN_W-1:0] dq_margin_o,
  output logic signed [MARGIN_W-1:0] strobe_margin_o
);
  localparam int MW = MARGIN_W;
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int LW = $clog2(2 * NBITS + 4);
  localparam logic [IW-1:0] LAST = IW'(NBITS - 1);
  localparam logic signed [MW-1:0] INIT_M = MW'(DLY_MAX + 1);
  localparam logic [LW-1:0] RUN_CYC = LW'(2 * NBITS + 1);

  ctr_state_e state_q;
  logic [IW-1:0] idx_q;
  logic signed [EDGE_W-1:0] left_q  [NBITS];
  logic signed [EDGE_W-1:0] right_q [NBITS];
  logic [DLY_W-1:0] cur_q [NBITS];
  logic [DLY_W-1:0] dly_q [NBITS];
  logic [DQS_W-1:0] sstart_q;
  logic signed [MW-1:0] half_q, move_q;
  logic signed [MW-1:0] dq_acc_q, st_acc_q;
  logic [LW-1:0] lat_q;

  logic signed [MW-1:0] sel_left, sel_right, sel_mid, min_mid;
  logic signed [MW-1:0] half_c, move_c, lmarg, rmarg, dq_next, st_next;
  logic [DQS_W-1:0] strobe_c;
  logic [DLY_W-1:0] new_dly;
  logic accept, scan_en;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign scan_en = (state_q == ST_SCAN);

  always_comb begin
    sel_left  = MW'(left_q[idx_q]);
    sel_right = MW'(right_q[idx_q]);
    sel_mid   = sel_left - sel_right;
    dq_next   = (lmarg < dq_acc_q) ? lmarg : dq_acc_q;
    st_next   = (rmarg < st_acc_q) ? rmarg : st_acc_q;
  end

  eye_min_scan #(.MW(MW)) u_scan (
    .clk(clk), .rst(rst), .clear_i(accept), .en_i(scan_en),
    .val_i(sel_mid), .min_o(min_mid)
  );

  eye_strobe_calc #(
    .MW(MW), .DQS_W(DQS_W), .STROBE_MAX(STROBE_MAX), .MOVE_STROBE(MOVE_STROBE)
  ) u_strobe (
    .min_mid_i(min_mid), .start_i(sstart_q),
    .half_o(half_c), .move_o(move_c), .strobe_o(strobe_c)
  );

  eye_bit_shift #(.MW(MW), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_shift (
    .mid_i(sel_mid), .min_mid_i(min_mid), .half_i(half_q), .move_i(move_q),
    .left_i(sel_left), .right_i(sel_right), .cur_i(cur_q[idx_q]),
    .new_o(new_dly), .lmarg_o(lmarg), .rmarg_o(rmarg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      idx_q           <= '0;
      busy_o          <= 1'b0;
      done_o          <= 1'b0;
      pass_o          <= 1'b0;
      strobe_dly_o    <= '0;
      dq_margin_o     <= '0;
      strobe_margin_o <= '0;
      sstart_q        <= '0;
      half_q          <= '0;
      move_q          <= '0;
      dq_acc_q        <= '0;
      st_acc_q        <= '0;
      lat_q           <= '0;
      for (int b = 0; b < NBITS; b++) begin
        left_q[b]  <= '0;
        right_q[b] <= '0;
        cur_q[b]   <= '0;
        dly_q[b]   <= '0;
      end
    end else begin
      done_o <= 1'b0;
      if (busy_o) lat_q <= lat_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            for (int b = 0; b < NBITS; b++) begin
              left_q[b]  <= left_edges_i[b*EDGE_W +: EDGE_W];
              right_q[b] <= right_edges_i[b*EDGE_W +: EDGE_W];
              cur_q[b]   <= cur_dly_i[b*DLY_W +: DLY_W];
            end
            sstart_q <= strobe_start_i;
            idx_q    <= '0;
            busy_o   <= 1'b1;
            lat_q    <= '0;
            state_q  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_STROBE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_STROBE: begin
          half_q       <= half_c;
          move_q       <= move_c;
          strobe_dly_o <= strobe_c;
          dq_acc_q     <= INIT_M;
          st_acc_q     <= INIT_M;
          state_q      <= ST_SHIFT;
        end
        ST_SHIFT: begin
          dly_q[idx_q] <= new_dly;
          dq_acc_q     <= dq_next;
          st_acc_q     <= st_next;
          if (idx_q == LAST) begin
            idx_q           <= '0;
            busy_o          <= 1'b0;
            done_o          <= 1'b1;
            pass_o          <= !dq_next[MW-1] && !st_next[MW-1];
            dq_margin_o     <= dq_next;
            strobe_margin_o <= st_next;
            state_q         <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < NBITS; gb++) begin : g_out
      assign dly_o[gb*DLY_W +: DLY_W] = dly_q[gb];
      p_dly_range_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (dly_o[gb*DLY_W +: DLY_W] <= DLY_W'(DLY_MAX)));
    end
    if (!MOVE_STROBE) begin : g_wr_chk
      p_strobe_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (strobe_dly_o == sstart_q));
    end
  endgenerate

  p_strobe_range_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (strobe_dly_o <= DQS_W'(STROBE_MAX)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(sstart_q));
  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == RUN_CYC));
endmodule

// File: tb/eye_centre_calc_tb_top.sv
module eye_centre_calc_tb_top;
  localparam int NB = 4;
  localparam int EW = 8;
  localparam int DW = 5;
  localparam int SW = 5;
  localparam int MW = 16;
  localparam int DMAX = 31;
  localparam int SMAX = 31;
  localparam int NV = 6;

  // stimulus: left, right, current delays, strobe start; expected read strobe and pass
  localparam int TL [NV][NB] = '{'{5,6,4,7}, '{7,8,9,10}, '{10,10,10,10},
                                 '{0,0,0,0}, '{-3,2,2,2}, '{10,10,10,10}};
  localparam int TR [NV][NB] = '{'{5,4,6,3}, '{2,2,2,2}, '{0,0,0,0},
                                 '{10,10,10,10}, '{2,2,2,2}, '{0,0,0,0}};
  localparam int TC [NV][NB] = '{'{10,10,10,10}, '{15,15,15,15}, '{20,20,20,20},
                                 '{2,30,30,30}, '{10,10,10,10}, '{29,29,29,29}};
  localparam int TS [NV] = '{12, 10, 1, 30, 10, 1};
  localparam int TXS [NV] = '{13, 7, 0, 31, 12, 0};
  localparam int TXP [NV] = '{1, 1, 1, 1, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NB*EW-1:0] lbus = '0, rbus = '0;
  logic [NB*DW-1:0] cbus = '0;
  logic [SW-1:0] sbus = '0;
  logic busy_r, done_r, pass_r, busy_w, done_w, pass_w;
  logic [SW-1:0] str_r, str_w;
  logic [NB*DW-1:0] dly_r, dly_w;
  logic signed [MW-1:0] dqm_r, stm_r, dqm_w, stm_w;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  eye_centre_calc #(.NBITS(NB), .EDGE_W(EW), .DLY_W(DW), .DLY_MAX(DMAX), .DQS_W(SW),
    .STROBE_MAX(SMAX), .MARGIN_W(MW), .MOVE_STROBE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .left_edges_i(lbus), .right_edges_i(rbus),
    .cur_dly_i(cbus), .strobe_start_i(sbus), .busy_o(busy_r), .done_o(done_r),
    .pass_o(pass_r), .strobe_dly_o(str_r), .dly_o(dly_r), .dq_margin_o(dqm_r),
    .strobe_margin_o(stm_r));

  eye_centre_calc #(.NBITS(NB), .EDGE_W(EW), .DLY_W(DW), .DLY_MAX(DMAX), .DQS_W(SW),
    .STROBE_MAX(SMAX), .MARGIN_W(MW), .MOVE_STROBE(1'b0)) dut_w_i (
    .clk(clk), .rst(rst), .start_i(start), .left_edges_i(lbus), .right_edges_i(rbus),
    .cur_dly_i(cbus), .strobe_start_i(sbus), .busy_o(busy_w), .done_o(done_w),
    .pass_o(pass_w), .strobe_dly_o(str_w), .dly_o(dly_w), .dq_margin_o(dqm_w),
    .strobe_margin_o(stm_w));

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent model written from the requirements
  task automatic model(input int v, input bit mv, output int nd[NB], output int ns,
                       output int dqm, output int stm, output int ps);
    int mn, h, mvv, sh;
    mn = TL[v][0] - TR[v][0];
    for (int b = 1; b < NB; b++)
      if (TL[v][b] - TR[v][b] < mn) mn = TL[v][b] - TR[v][b];
    h = (mn > 0) ? (mn + 1) / 2 : mn / 2;
    if (mv) begin
      ns = TS[v] - h;
      if (ns < 0) ns = 0;
      if (ns > SMAX) ns = SMAX;
      mvv = TS[v] - ns;
    end else begin
      ns = TS[v];
      mvv = 0;
    end
    dqm = DMAX + 1;
    stm = DMAX + 1;
    for (int b = 0; b < NB; b++) begin
      sh = (TL[v][b] - TR[v][b] - mn) / 2 + (h - mvv);
      if (TC[v][b] + sh > DMAX) sh = DMAX - TC[v][b];
      else if (TC[v][b] + sh < 0) sh = -TC[v][b];
      nd[b] = TC[v][b] + sh;
      if (TL[v][b] - sh - mvv < dqm) dqm = TL[v][b] - sh - mvv;
      if (TR[v][b] + sh + mvv < stm) stm = TR[v][b] + sh + mvv;
    end
    ps = (dqm >= 0 && stm >= 0) ? 1 : 0;
  endtask

  task automatic load_vec(input int v);
    for (int b = 0; b < NB; b++) begin
      lbus[b*EW +: EW] = EW'(TL[v][b]);
      rbus[b*EW +: EW] = EW'(TR[v][b]);
      cbus[b*DW +: DW] = DW'(TC[v][b]);
    end
    sbus = SW'(TS[v]);
  endtask

  // returns number of rising edges from acceptance edge until done is seen
  task automatic run(output int edges);
    edges = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done_r && edges < 100) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    int nd[NB], ns, dqm, stm, ps, edges;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_r && !done_r && !pass_r, "R1 flags", {busy_r, done_r, pass_r}, 0);
    chk(str_r == 0 && dly_r == 0, "R1 outputs", int'(str_r), 0);
    chk(dqm_r == 0 && stm_r == 0, "R1 margins", int'(dqm_r), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load_vec(v);
      run(edges);
      // R11: latency 2*NB+1 edges after the accepting edge
      chk(edges == 2 * NB + 2, "R11 latency", edges, 2 * NB + 2);
      chk(done_w == 1'b1, "R11 write done", int'(done_w), 1);
      // R3 R4: read-side strobe from the table
      chk(int'(str_r) == TXS[v], "R3 R4 read strobe", int'(str_r), TXS[v]);
      chk(int'(pass_r) == TXP[v], "R9 read pass", int'(pass_r), TXP[v]);
      model(v, 1'b1, nd, ns, dqm, stm, ps);
      for (int b = 0; b < NB; b++)
        chk(int'(dly_r[b*DW +: DW]) == nd[b], "R6 R7 read delay", int'(dly_r[b*DW +: DW]), nd[b]);
      chk(int'(dqm_r) == dqm, "R8 read data margin", int'(dqm_r), dqm);
      chk(int'(stm_r) == stm, "R8 read strobe margin", int'(stm_r), stm);
      chk(int'(pass_r) == ps, "R9 read pass model", int'(pass_r), ps);
      model(v, 1'b0, nd, ns, dqm, stm, ps);
      // R5: write side strobe stays put
      chk(int'(str_w) == TS[v], "R5 write strobe", int'(str_w), TS[v]);
      for (int b = 0; b < NB; b++)
        chk(int'(dly_w[b*DW +: DW]) == nd[b], "R5 R6 write delay", int'(dly_w[b*DW +: DW]), nd[b]);
      chk(int'(dqm_w) == dqm, "R8 write data margin", int'(dqm_w), dqm);
      chk(int'(stm_w) == stm, "R8 write strobe margin", int'(stm_w), stm);
      chk(int'(pass_w) == ps, "R9 write pass", int'(pass_w), ps);
      @(negedge clk);
      chk(!done_r, "R10 done pulse width", int'(done_r), 0);
    end

    // R10: results hold while idle even if inputs change
    load_vec(0);
    repeat (5) @(negedge clk);
    chk(int'(str_r) == TXS[NV-1], "R10 hold strobe", int'(str_r), TXS[NV-1]);
    chk(int'(pass_r) == TXP[NV-1], "R10 hold pass", int'(pass_r), TXP[NV-1]);

    // R10: start during a run is ignored; vector 0 result must appear once
    begin
      int dones;
      dones = 0;
      load_vec(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      load_vec(4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 30; c++) begin
        if (done_r) begin
          dones++;
          chk(int'(str_r) == TXS[0], "R10 ignored start strobe", int'(str_r), TXS[0]);
          chk(int'(pass_r) == TXP[0], "R10 ignored start pass", int'(pass_r), TXP[0]);
        end
        @(negedge clk);
      end
      chk(dones == 1, "R10 single done", dones, 1);
    end

    // R1: reset in the middle of a run
    load_vec(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy_r && !done_r && str_r == 0, "R1 mid-run reset", int'(busy_r), 0);
    repeat (20) @(negedge clk);
    chk(!done_r && !busy_r, "R1 no late done", int'(done_r), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule